// File: doc/BRIEF.md
# System-Management Memory Access Router

This block sits in the address path of a memory controller and decides where each CPU access goes. It guards system-management memory: a 128 KiB legacy window at 0xA0000–0xBFFFF, a high alias of the same DRAM at 0xFEDA0000–0xFEDBFFFF, and a protected region just below the top of low memory. Every access carries an address, byte enables, a write flag and a flag that says whether the CPU is in system-management mode. The block gives accesses in that mode and accesses outside it different views of memory. It picks one route for each access: DRAM, the legacy video/PCI path, a black-hole responder, or pass-through to the normal map.

Two 8-bit control registers are written over a plain config port. The mode register holds the open, lock and global-enable bits. The extension register holds the high-alias select, the protected-region enable and a size code. Setting the lock bit closes the window and freezes both registers until reset.

Requests flow on a valid/ready pair. The routing decision is combinational, so the route output is valid in the same cycle as the request. `rt_valid` follows `req_valid`, and `req_ready` follows `rt_ready`. A request must be held stable while `rt_ready` is low. It is consumed in the cycle where both `req_valid` and `rt_ready` are high.

Top module: `smrd_top`

## Requirements
- R1: After reset, both control registers read 0x00.
- R2: Mode register bits are open (bit 0), lock (bit 1) and global enable (bit 2). Extension register bits are high select (bit 0), region enable (bit 1) and size code (bits 3:2). Bits above these are not writable and read 0. `cfg_sel` 0 picks the mode register and 1 picks the extension register.
- R3: A written lock bit forces open to 0 in the same write, even when open is written as 1. While locked, writes to both registers have no effect until reset.
- R4: Outside management mode, the legacy window routes to DRAM (code 1) when open=1 and high select=0. Otherwise it routes to the legacy path (code 2).
- R5: Outside management mode, the high window routes to DRAM only when open=1 and high select=1. Otherwise it passes to the normal map (code 0).
- R6: In management mode with global enable=1, the legacy window routes to DRAM when high select=0, and the high window routes to DRAM when high select=1. Every other management-mode window access is routed as it would be outside management mode.
- R7: With region enable=1, size code 0 gives a 1 MiB region, code 1 gives 2 MiB, code 2 gives 8 MiB, and code 3 gives no region. The region spans [TOLM − size, TOLM).
- R8: Outside management mode, a region hit routes to the black hole (code 3). A read returns 0xFFFFFFFF whatever the byte enables. A write raises `rt_wr_drop`.
- R9: In management mode, a region hit routes to DRAM and never to the black hole.
- R10: `rt_valid` equals `req_valid`, `req_ready` equals `rt_ready`, and `rt_be` carries `req_be`, all in the same cycle. Addresses outside every window route to code 0. `rt_rdata` is 0 unless the route is a black-hole read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 1 | 0 selects the mode register, 1 the extension register |
| cfg_wdata | input | 8 | Config write data |
| mode_q | output | 8 | Mode register readback |
| ext_q | output | 8 | Extension register readback |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted |
| req_addr | input | 32 | Access byte address |
| req_be | input | 4 | Byte enables, 1 to 4 bytes |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Access issued in management mode |
| rt_valid | output | 1 | Route output valid |
| rt_ready | input | 1 | Downstream ready |
| rt_route | output | 2 | 0 normal map, 1 DRAM, 2 legacy path, 3 black hole |
| rt_be | output | 4 | Byte enables forwarded |
| rt_rdata | output | 32 | Black-hole read data |
| rt_wr_drop | output | 1 | Write discarded by the black hole |

## Verification
The routing is tried over every value of the three mode bits and every value of the extension register, and each combination is run in and out of management mode. This separates the open-window view from the management-mode view, and the high alias from the legacy window. Each combination is probed at the first and last byte of every window and of each possible protected-region size, and one byte outside each of them. A size-code error or an off-by-one bound therefore shows up as a wrong route. Locked combinations are followed by attempted rewrites of both registers, so a leaky lock shows up in the readback and in the routes that follow. Random byte enables and random downstream stalls show that the read data is all ones for any byte enables and that the handshake passes straight through.

// File: rtl/smrd_pkg.sv
package smrd_pkg;
  typedef enum logic [1:0] {
    RT_PASS   = 2'd0,
    RT_DRAM   = 2'd1,
    RT_LEGACY = 2'd2,
    RT_HOLE   = 2'd3
  } route_e;

  localparam int MODE_OPEN = 0;
  localparam int MODE_LOCK = 1;
  localparam int MODE_GEN  = 2;
  localparam int EXT_HIGH  = 0;
  localparam int EXT_TEN   = 1;
  localparam int EXT_SZ_LO = 2;

  typedef struct packed {
    logic       open;
    logic       lock;
    logic       gen;
    logic       high;
    logic       tseg_en;
    logic [1:0] sz;
  } ctrl_t;
endpackage

// File: rtl/smrd_ctrl_regs.sv
module smrd_ctrl_regs
  import smrd_pkg::*;
#(
  parameter int         RW          = 8,
  parameter logic [7:0] MODE_RST    = 8'h00,
  parameter logic [7:0] EXT_RST     = 8'h00,
  parameter logic [7:0] MODE_MASK   = 8'h07,
  parameter logic [7:0] MODE_MASK_L = 8'h00,
  parameter logic [7:0] EXT_MASK    = 8'h0F,
  parameter logic [7:0] EXT_MASK_L  = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] mode_q,
  output logic [RW-1:0] ext_q,
  output ctrl_t         ctrl
);
  logic [RW-1:0] mode_mask, ext_mask, mode_nx, ext_nx;

  always_comb begin
    mode_mask = mode_q[MODE_LOCK] ? MODE_MASK_L : MODE_MASK;
    ext_mask  = mode_q[MODE_LOCK] ? EXT_MASK_L  : EXT_MASK;
    mode_nx   = mode_q;
    ext_nx    = ext_q;
    if (cfg_we) begin
      if (!cfg_sel) mode_nx = (mode_q & ~mode_mask) | (cfg_wdata & mode_mask);
      else          ext_nx  = (ext_q  & ~ext_mask)  | (cfg_wdata & ext_mask);
    end
    if (mode_nx[MODE_LOCK]) mode_nx[MODE_OPEN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      ext_q  <= EXT_RST;
    end else begin
      mode_q <= mode_nx;
      ext_q  <= ext_nx;
    end
  end

  always_comb begin
    ctrl.open    = mode_q[MODE_OPEN];
    ctrl.lock    = mode_q[MODE_LOCK];
    ctrl.gen     = mode_q[MODE_GEN];
    ctrl.high    = ext_q[EXT_HIGH];
    ctrl.tseg_en = ext_q[EXT_TEN];
    ctrl.sz      = ext_q[EXT_SZ_LO +: 2];
  end
endmodule

// File: rtl/smrd_win_match.sv
module smrd_win_match #(
  parameter int              AW   = 32,
  parameter logic [AW-1:0]   BASE = '0,
  parameter logic [AW-1:0]   SIZE = 'h20000
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] LAST = BASE + SIZE - 1'b1;
  assign hit = (addr >= BASE) && (addr <= LAST);
endmodule

// File: rtl/smrd_tseg_match.sv
module smrd_tseg_match #(
  parameter int            AW   = 32,
  parameter logic [AW-1:0] TOLM = 32'h8000_0000
) (
  input  logic          en,
  input  logic [1:0]    sz,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] MIB = AW'(1) << 20;
  logic [AW-1:0] size, lo;

  always_comb begin
    unique case (sz)
      2'd0:    size = MIB;
      2'd1:    size = MIB << 1;
      2'd2:    size = MIB << 3;
      default: size = '0;
    endcase
    if (!en) size = '0;
    lo  = TOLM - size;
    hit = (size != '0) && (addr >= lo) && (addr < TOLM);
  end
endmodule

// File: rtl/smrd_route_sel.sv
module smrd_route_sel
  import smrd_pkg::*;
#(
  parameter int DW = 32
) (
  input  ctrl_t         ctrl,
  input  logic          in_low,
  input  logic          in_high,
  input  logic          in_tseg,
  input  logic          smm,
  input  logic          wr,
  output route_e        route,
  output logic [DW-1:0] rdata,
  output logic          wr_drop
);
  route_e base_rt;

  always_comb begin
    if (in_low)       base_rt = (ctrl.open && !ctrl.high) ? RT_DRAM : RT_LEGACY;
    else if (in_high) base_rt = (ctrl.open && ctrl.high) ? RT_DRAM : RT_PASS;
    else              base_rt = RT_PASS;

    if (in_tseg)                                    route = smm ? RT_DRAM : RT_HOLE;
    else if (smm && ctrl.gen && in_low && !ctrl.high) route = RT_DRAM;
    else if (smm && ctrl.gen && in_high && ctrl.high) route = RT_DRAM;
    else                                            route = base_rt;

    rdata   = (route == RT_HOLE && !wr) ? '1 : '0;
    wr_drop = (route == RT_HOLE) && wr;
  end
endmodule

// File: rtl/smrd_top.sv
module smrd_top
  import smrd_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter int            RW        = 8,
  parameter logic [AW-1:0] TOLM      = 32'h8000_0000,
  parameter logic [AW-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [AW-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [AW-1:0] WIN_SIZE  = 32'h0002_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [RW-1:0]   cfg_wdata,
  output logic [RW-1:0]   mode_q,
  output logic [RW-1:0]   ext_q,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW/8-1:0] req_be,
  input  logic            req_wr,
  input  logic            req_smm,
  output logic            rt_valid,
  input  logic            rt_ready,
  output logic [1:0]      rt_route,
  output logic [DW/8-1:0] rt_be,
  output logic [DW-1:0]   rt_rdata,
  output logic            rt_wr_drop
);
  localparam int NWIN = 2;
  localparam logic [NWIN-1:0][AW-1:0] WBASE = {HIGH_BASE, LOW_BASE};

  ctrl_t          ctrl;
  logic [NWIN-1:0] win_hit;
  logic           tseg_hit;
  route_e         route;

  smrd_ctrl_regs #(.RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mode_q(mode_q), .ext_q(ext_q), .ctrl(ctrl)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    smrd_win_match #(.AW(AW), .BASE(WBASE[w]), .SIZE(WIN_SIZE)) u_win (
      .addr(req_addr), .hit(win_hit[w])
    );
  end

  smrd_tseg_match #(.AW(AW), .TOLM(TOLM)) u_tseg (
    .en(ctrl.tseg_en), .sz(ctrl.sz), .addr(req_addr), .hit(tseg_hit)
  );

  smrd_route_sel #(.DW(DW)) u_sel (
    .ctrl(ctrl), .in_low(win_hit[0]), .in_high(win_hit[1]), .in_tseg(tseg_hit),
    .smm(req_smm), .wr(req_wr), .route(route), .rdata(rt_rdata),
    .wr_drop(rt_wr_drop)
  );

  assign rt_route  = route;
  assign rt_valid  = req_valid;
  assign req_ready = rt_ready;
  assign rt_be     = req_be;
endmodule

// File: rtl/smrd_checker.sv
module smrd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  mode_q,
  input logic [7:0]  ext_q,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_wr,
  input logic        req_smm,
  input logic        rt_valid,
  input logic        rt_ready,
  input logic [1:0]  rt_route,
  input logic [31:0] rt_rdata
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[7:3] == 5'd0) && (ext_q[7:4] == 4'd0));

  p_lock_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> !mode_q[0]);

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |=> mode_q[1]);

  p_locked_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |=> ($stable(mode_q) && $stable(ext_q)));

  p_hole_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_route == 2'd3 && !req_wr) |-> (rt_rdata == 32'hFFFF_FFFF));

  p_smm_no_hole_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_smm) |-> (rt_route != 2'd3));

  p_flow_through_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid == req_valid) && (req_ready == rt_ready));
endmodule

bind smrd_top smrd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .ext_q(ext_q),
  .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
  .req_smm(req_smm), .rt_valid(rt_valid), .rt_ready(rt_ready),
  .rt_route(rt_route), .rt_rdata(rt_rdata)
);

// File: tb/tb_smrd_top.sv
`timescale 1ns/1ps
module tb_smrd_top;
  localparam logic [31:0] TOLM = 32'h8000_0000;
  localparam longint MIB = 64'd1 << 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] mode_q, ext_q;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0] req_be = 4'hF;
  logic req_wr = 1'b0, req_smm = 1'b0;
  logic rt_valid, rt_ready = 1'b1;
  logic [1:0] rt_route;
  logic [3:0] rt_be;
  logic [31:0] rt_rdata;
  logic rt_wr_drop;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] m_mode = '0, m_ext = '0;

  always #2.5 clk = ~clk;

  smrd_top #(.TOLM(TOLM)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mode_q(mode_q), .ext_q(ext_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_be(req_be), .req_wr(req_wr), .req_smm(req_smm),
    .rt_valid(rt_valid), .rt_ready(rt_ready), .rt_route(rt_route),
    .rt_be(rt_be), .rt_rdata(rt_rdata), .rt_wr_drop(rt_wr_drop)
  );

  // Behavioural register model: lock freezes everything, lock wins over open.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 8'h00;
      m_ext  <= 8'h00;
    end else if (cfg_we && !m_mode[1]) begin
      if (!cfg_sel) m_mode <= (cfg_wdata[1] ? (cfg_wdata & 8'h06) : (cfg_wdata & 8'h07));
      else          m_ext  <= cfg_wdata & 8'h0F;
    end
  end

  function automatic longint region_size(logic [7:0] e);
    if (!e[1]) return 0;
    case (e[3:2])
      2'd0: return MIB;
      2'd1: return 2 * MIB;
      2'd2: return 8 * MIB;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_route(logic [7:0] md, logic [7:0] e, logic [31:0] a, logic smm);
    longint ad = longint'(a);
    longint sz = region_size(e);
    bit lo = (ad >= 64'hA0000) && (ad <= 64'hBFFFF);
    bit hi = (ad >= 64'hFEDA0000) && (ad <= 64'hFEDBFFFF);
    bit ts = (sz != 0) && (ad >= longint'(TOLM) - sz) && (ad < longint'(TOLM));
    if (ts) return smm ? 1 : 3;
    if (smm && md[2] && lo && !e[0]) return 1;
    if (smm && md[2] && hi && e[0]) return 1;
    if (lo) return (md[0] && !e[0]) ? 1 : 2;
    if (hi) return (md[0] && e[0]) ? 1 : 0;
    return 0;
  endfunction

  function automatic string tag_for(logic [31:0] a, logic smm);
    longint ad = longint'(a);
    if (ad >= longint'(TOLM) - 8 * MIB - 1 && ad <= longint'(TOLM)) return smm ? "R7,R9" : "R7,R8";
    if (ad >= 64'h9FFFF && ad <= 64'hC0000) return smm ? "R6" : "R4";
    if (ad >= 64'hFED9FFFF && ad <= 64'hFEDC0000) return smm ? "R6" : "R5";
    return "R10";
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(mode_q == m_mode, m_mode[1] ? "R3" : "R2", "mode reg", mode_q, m_mode);
      chk(ext_q == m_ext, m_mode[1] ? "R3" : "R2", "ext reg", ext_q, m_ext);
      chk(rt_valid == req_valid && req_ready == rt_ready && rt_be == req_be,
          "R10", "handshake", {rt_valid, req_ready, rt_be}, {req_valid, rt_ready, req_be});
      if (req_valid) begin
        int er;
        er = exp_route(m_mode, m_ext, req_addr, req_smm);
        chk(int'(rt_route) == er, tag_for(req_addr, req_smm), "route", rt_route, er);
        chk(rt_rdata == ((er == 3 && !req_wr) ? 32'hFFFF_FFFF : 32'h0), "R8", "rdata",
            rt_rdata, (er == 3 && !req_wr) ? 32'hFFFF_FFFF : 32'h0);
        chk(rt_wr_drop == (er == 3 && req_wr), "R8", "drop", rt_wr_drop, (er == 3 && req_wr));
      end
    end
  end

  function automatic logic [31:0] probe(int i);
    case (i)
      0: return 32'h0009_FFFF;   1: return 32'h000A_0000;
      2: return 32'h000A_FFFC;   3: return 32'h000B_FFFF;
      4: return 32'h000C_0000;   5: return 32'hFED9_FFFF;
      6: return 32'hFEDA_0000;   7: return 32'hFEDB_FFFF;
      8: return 32'hFEDC_0000;   9: return TOLM - 32'h0080_0001;
      10: return TOLM - 32'h0080_0000; 11: return TOLM - 32'h0020_0001;
      12: return TOLM - 32'h0020_0000; 13: return TOLM - 32'h0010_0001;
      14: return TOLM - 32'h0010_0000; 15: return TOLM - 32'h1;
      16: return TOLM;           default: return 32'h0000_1000;
    endcase
  endfunction

  task automatic cfg_write(logic sel, logic [7:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic sweep();
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 18; i++) begin
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_addr  = probe(i);
        req_smm   = s[0];
        req_wr    = i[0];
        req_be    = 4'($urandom_range(1, 15));
        rt_ready  = ($urandom_range(0, 3) != 0);
      end
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mode_q == 8'h00 && ext_q == 8'h00, "R1", "reset value", {mode_q, ext_q}, 16'h0);
    for (int mv = 0; mv < 8; mv++) begin
      for (int ev = 0; ev < 16; ev++) begin
        do_reset();
        @(negedge clk);
        chk(mode_q == 8'h00 && ext_q == 8'h00, "R1", "reset after lock", {mode_q, ext_q}, 16'h0);
        cfg_write(1'b1, 8'(ev) | 8'hF0);
        cfg_write(1'b0, 8'(mv) | 8'hF8);
        sweep();
        if (mv[1]) begin
          // R3: rewrites after lock must leave both registers and the routes unchanged
          cfg_write(1'b0, 8'h05);
          cfg_write(1'b1, 8'(ev) ^ 8'h0F);
          sweep();
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule